// File: doc/BRIEF.md
# Serial Video Word-Aligning Deserializer

This block turns a recovered one-bit serial digital video stream into 10-bit parallel words. It runs entirely on the recovered bit clock. Each incoming bit is descrambled by a self-synchronizing descrambler with polynomial x^9+x^4+1 and then NRZI-decoded. The decoded bits pass through a 30-bit window. Words are received least significant bit first. The block raises a parallel clock at one tenth of the bit rate, with its rising edge in the middle of each output word.

Word framing comes from the timing reference preamble. The preamble is one all-ones word followed by two all-zeros words, and it can be found at any bit offset in the window. A preamble that lands on the current word boundary is accepted. A preamble at any other position is reported as misplaced. With correction disabled, a misplaced preamble moves the word boundary at once. With correction enabled, one misplaced preamble is tolerated, and only a second consecutive one moves the boundary. For every accepted preamble, the horizontal sync output changes level one word period before the all-ones word reaches the parallel output. Only the moment of that change carries meaning, not the level.

Top module: `sdv_deser`

## Requirements
- R1: Each serial bit is descrambled as n = s ^ s(t-4) ^ s(t-9) and NRZI-decoded as b = n ^ n(t-1). Descrambler history and NRZI state reset to zero. Bits are received LSB first, so the first bit of a word lands in `pdata[0]`.
- R2: The preamble is the decoded word 3FF followed by the words 000 and 000 (hex). It is recognised at whatever bit offset it arrives.
- R3: Ten bit clocks after `hsync` changes level, `pdata` shows 3FF. Words 000 and 000 follow, each ten bit clocks apart, and then the following words in order.
- R4: `hsync` changes level exactly once per accepted preamble. It does so in the same cycle that `pclk` is driven low.
- R5: `pclk` is low for 5 and high for 5 bit clocks of each word period, counting from the last word boundary. `pdata` changes only when `pclk` goes low, never when it rises.
- R6: With `corr_en` low, a misplaced preamble sets a new word boundary immediately and is accepted.
- R7: With `corr_en` high and no pending strike, a misplaced preamble is not accepted and the word boundary is kept. A second consecutive misplaced preamble sets the new boundary and is accepted.
- R8: A preamble that arrives on the current boundary clears any pending strike.
- R9: `trs_valid` is a one-cycle pulse coinciding with each `hsync` change. `sync_err` is a one-cycle pulse for each misplaced preamble, whether or not that preamble is accepted.
- R10: During reset, `pdata`, `pclk`, `hsync`, `trs_valid` and `sync_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Scrambled serial data bit |
| corr_en | input | 1 | Enables the two-strike resynchronization rule |
| pdata | output | 10 | Descrambled parallel word, bit 0 received first |
| pclk | output | 1 | Parallel clock, bit clock divided by ten |
| hsync | output | 1 | Changes level for each accepted preamble |
| trs_valid | output | 1 | One-cycle pulse per accepted preamble |
| sync_err | output | 1 | One-cycle pulse per misplaced preamble |

## Verification
The hardest state to reach is a pending strike that must later be cleared. Reaching it needs a misplaced preamble under correction, then an aligned one, then another misplaced one. The bench inserts extra bits between lines to shift the stream's word phase. Inserting three bits moves the preamble off the boundary. Inserting seven more bits completes a whole word and restores the original alignment. This lets the bench tell a tolerated strike, a cleared strike and a realignment apart using only `hsync`, `sync_err` and the parallel data.

// File: rtl/sdv_pkg.sv
package sdv_pkg;
    localparam int unsigned SDV_WORD_W   = 10;
    localparam int unsigned SDV_POLY_LEN = 9;
    localparam int unsigned SDV_POLY_TAP = 4;
endpackage

// File: rtl/sdv_descramble.sv
module sdv_descramble #(
    parameter int unsigned POLY_LEN = sdv_pkg::SDV_POLY_LEN,
    parameter int unsigned POLY_TAP = sdv_pkg::SDV_POLY_TAP
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    output logic bit_out
);
    typedef struct packed {
        logic [POLY_LEN-1:0] hist;
        logic                nrz_prev;
        logic                bit_o;
    } ds_t;

    ds_t ds_d, ds_q;
    logic nrz;

    always_comb begin
        nrz           = ser_in ^ ds_q.hist[POLY_TAP-1] ^ ds_q.hist[POLY_LEN-1];
        ds_d          = ds_q;
        ds_d.hist     = {ds_q.hist[POLY_LEN-2:0], ser_in};
        ds_d.nrz_prev = nrz;
        ds_d.bit_o    = nrz ^ ds_q.nrz_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ds_q <= '0;
        else        ds_q <= ds_d;
    end

    assign bit_out = ds_q.bit_o;
endmodule

// File: rtl/sdv_trs_find.sv
module sdv_trs_find #(
    parameter int unsigned WORD_W = sdv_pkg::SDV_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    output logic              found,
    output logic [WORD_W-1:0] oldest
);
    localparam int unsigned WIN_W = 3 * WORD_W;

    typedef struct packed {
        logic [WIN_W-1:0] win;
    } tf_t;

    tf_t tf_d, tf_q;

    always_comb begin
        tf_d     = tf_q;
        tf_d.win = {bit_in, tf_q.win[WIN_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tf_q <= '0;
        else        tf_q <= tf_d;
    end

    assign oldest = tf_q.win[WORD_W-1:0];
    assign found  = (tf_q.win[WORD_W-1:0] == {WORD_W{1'b1}}) &&
                    (tf_q.win[WIN_W-1:WORD_W] == '0);
endmodule

// File: rtl/sdv_framer.sv
module sdv_framer #(
    parameter int unsigned WORD_W = sdv_pkg::SDV_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              corr_en,
    input  logic              found,
    input  logic [WORD_W-1:0] oldest,
    output logic [WORD_W-1:0] pdata,
    output logic              pclk,
    output logic              hsync,
    output logic              trs_valid,
    output logic              sync_err
);
    localparam int unsigned PH_W = $clog2(WORD_W);
    localparam int unsigned LAST = WORD_W - 1;
    localparam int unsigned HALF = WORD_W / 2;

    typedef struct packed {
        logic [PH_W-1:0]   phase;
        logic              strike;
        logic [WORD_W-1:0] hold;
        logic [WORD_W-1:0] pdata;
        logic              pclk;
        logic              hsync;
        logic              valid;
        logic              err;
    } fr_t;

    fr_t fr_d, fr_q;
    logic at_end, misplaced, realign, accept, word_end;

    always_comb begin
        fr_d       = fr_q;
        fr_d.valid = 1'b0;
        fr_d.err   = 1'b0;

        at_end    = (fr_q.phase == PH_W'(LAST));
        misplaced = found && !at_end;
        realign   = misplaced && (!corr_en || fr_q.strike);
        accept    = (found && at_end) || realign;
        word_end  = at_end || realign;

        fr_d.phase = word_end ? '0 : fr_q.phase + PH_W'(1);
        if (word_end) begin
            fr_d.hold  = oldest;
            fr_d.pdata = fr_q.hold;
        end
        if (accept) begin
            fr_d.hsync  = ~fr_q.hsync;
            fr_d.valid  = 1'b1;
            fr_d.strike = 1'b0;
        end else if (misplaced) begin
            fr_d.strike = 1'b1;
        end
        if (misplaced) fr_d.err = 1'b1;
        fr_d.pclk = (fr_d.phase >= PH_W'(HALF));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign pdata     = fr_q.pdata;
    assign pclk      = fr_q.pclk;
    assign hsync     = fr_q.hsync;
    assign trs_valid = fr_q.valid;
    assign sync_err  = fr_q.err;

    assert_phase_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.phase <= PH_W'(LAST));

    assert_pdata_steady_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fr_q.pclk) |-> $stable(fr_q.pdata));

    assert_mark_with_low_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.valid |-> !fr_q.pclk);

    assert_mark_matches_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.hsync != $past(fr_q.hsync)) == fr_q.valid);

    assert_first_strike_tolerated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_en && found && !at_end && !fr_q.strike) |=> (!fr_q.valid && fr_q.strike && fr_q.err));

    assert_err_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.err |=> !fr_q.err);
endmodule

// File: rtl/sdv_deser.sv
module sdv_deser #(
    parameter int unsigned WORD_W   = sdv_pkg::SDV_WORD_W,
    parameter int unsigned POLY_LEN = sdv_pkg::SDV_POLY_LEN,
    parameter int unsigned POLY_TAP = sdv_pkg::SDV_POLY_TAP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              corr_en,
    output logic [WORD_W-1:0] pdata,
    output logic              pclk,
    output logic              hsync,
    output logic              trs_valid,
    output logic              sync_err
);
    logic              dec_bit;
    logic              trs_found;
    logic [WORD_W-1:0] old_word;

    sdv_descramble #(.POLY_LEN(POLY_LEN), .POLY_TAP(POLY_TAP)) u_descr (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .bit_out(dec_bit)
    );

    sdv_trs_find #(.WORD_W(WORD_W)) u_find (
        .clk(clk), .rst_n(rst_n), .bit_in(dec_bit),
        .found(trs_found), .oldest(old_word)
    );

    sdv_framer #(.WORD_W(WORD_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .corr_en(corr_en),
        .found(trs_found), .oldest(old_word),
        .pdata(pdata), .pclk(pclk), .hsync(hsync),
        .trs_valid(trs_valid), .sync_err(sync_err)
    );
endmodule

// File: tb/tb_sdv_deser.sv
module tb_sdv_deser;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       corr_en = 1'b0;
    logic [9:0] pdata;
    logic       pclk, hsync, trs_valid, sync_err;

    int checks = 0, errs = 0;
    int tog_seen = 0, err_seen = 0, val_seen = 0;
    int cur_line = 0, mon_line = 0, cnt = 0;
    bit mon_on = 0, done = 0;
    logic hs_prev = 1'b0;
    logic [8:0] tx_hist = '0;
    logic tx_nrz = 1'b0;

    sdv_deser dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .corr_en(corr_en),
        .pdata(pdata), .pclk(pclk), .hsync(hsync),
        .trs_valid(trs_valid), .sync_err(sync_err)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int payload(input int line, input int j);
        return 4 + ((line * 37 + j * 13) % 1000);
    endfunction

    task automatic send_bit(input logic b);
        logic n, s;
        n = b ^ tx_nrz;
        tx_nrz = n;
        s = n ^ tx_hist[3] ^ tx_hist[8];
        tx_hist = {tx_hist[7:0], s};
        @(negedge clk);
        ser_in = s;
    endtask

    task automatic send_word(input logic [9:0] w);
        for (int i = 0; i < 10; i++) send_bit(w[i]);
    endtask

    task automatic send_line(input int line);
        cur_line = line;
        send_word(10'h3FF);
        send_word(10'h000);
        send_word(10'h000);
        for (int j = 0; j < 8; j++) send_word(10'(payload(line, j)));
    endtask

    task automatic slip(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    // one line, then compare counter deltas
    task automatic line_expect(input int line, input int exp_tog, input int exp_err, input string req);
        int t0, e0, v0;
        t0 = tog_seen; e0 = err_seen; v0 = val_seen;
        send_line(line);
        chk(tog_seen - t0 == exp_tog, {req, " hsync changes"}, tog_seen - t0, exp_tog);
        chk(val_seen - v0 == exp_tog, {"R9 valid pulses ", req}, val_seen - v0, exp_tog);
        if (exp_err >= 0)
            chk(err_seen - e0 == exp_err, {req, " sync_err pulses"}, err_seen - e0, exp_err);
    endtask

    // output monitor, sampled on the falling clock edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mon_on) begin
                cnt = cnt + 1;
                if (cnt <= 110) begin
                    chk(pclk == ((cnt % 10) >= 5), "R5 pclk phase", pclk, int'((cnt % 10) >= 5));
                    if (cnt % 10 == 0) begin
                        int k, e;
                        k = cnt / 10;
                        if (k == 1)      e = 10'h3FF;
                        else if (k <= 3) e = 0;
                        else             e = payload(mon_line, k - 4);
                        chk(pdata == 10'(e), (k <= 3) ? "R3 preamble word order" : "R1 descrambled word",
                            pdata, e);
                    end
                end
            end
            if (sync_err) err_seen++;
            if (trs_valid) val_seen++;
            if (hsync != hs_prev) begin
                tog_seen++;
                chk(trs_valid == 1'b1, "R9 valid with hsync change", trs_valid, 1);
                chk(pclk == 1'b0, "R4 pclk low at hsync change", pclk, 0);
                mon_on = 1;
                cnt = 0;
                mon_line = cur_line;
            end
            hs_prev = hsync;
        end
    end

    initial begin
        #(100000 * 20);
        if (!done) begin
            done = 1;
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(pdata == 0, "R10 pdata in reset", pdata, 0);
        chk(pclk == 0, "R10 pclk in reset", pclk, 0);
        chk(hsync == 0, "R10 hsync in reset", hsync, 0);
        chk(trs_valid == 0, "R10 trs_valid in reset", trs_valid, 0);
        chk(sync_err == 0, "R10 sync_err in reset", sync_err, 0);
        rst_n = 1'b1;

        // correction disabled
        send_word(10'h155);
        send_word(10'h0AA);
        line_expect(0, 1, -1, "R2 first lock");
        line_expect(1, 1, 0, "R2 aligned line");
        line_expect(2, 1, 0, "R2 aligned line");
        slip(3);
        line_expect(3, 1, 1, "R6 immediate realign");
        line_expect(4, 1, 0, "R6 after realign");

        // correction enabled: two strikes
        corr_en = 1'b1;
        slip(3);
        line_expect(5, 0, 1, "R7 first strike ignored");
        line_expect(6, 1, 1, "R7 second strike realigns");
        line_expect(7, 1, 0, "R7 after realign");

        // strike cleared by aligned preamble
        slip(3);
        line_expect(8, 0, 1, "R7 strike keeps boundary");
        slip(7);
        line_expect(9, 1, 0, "R8 old boundary still valid");
        slip(3);
        line_expect(10, 0, 1, "R8 strike was cleared");
        slip(7);
        line_expect(11, 1, 0, "R8 aligned again");
        line_expect(12, 1, 0, "R2 steady line");
        repeat (20) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule